// File: doc/BRIEF.md
# Load-Use Stall and Branch Cycle Accounter

This block sits beside the retire point of an in-order pipeline and turns each retiring instruction's nominal cost into the cost it really had. The core presents every instruction with a one-cycle strobe. With it come:

- the instruction's class;
- its base cycle count;
- up to two source register indices, each with a presence flag;
- the destination register of a load;
- whether a branch was taken;
- whether that branch has a delay slot.

The block charges one extra cycle for every checked source that reads a register written by a load in the immediately preceding instruction. It charges one extra cycle for a taken branch that has no delay slot.

A two-stage scoreboard tracks which registers were just loaded. A pending mask is built while an instruction is accepted. It then becomes the active mask that the following instruction is checked against. The effective count is registered and shown as the last-instruction cost. Five saturating counters accumulate total cycles, load-stall cycles, branch-stall cycles, taken branches and untaken branches.

Top module: `cycle_accounter`

## Requirements
- R1: After reset, the last-instruction cost and all five counters read zero, and the scoreboard holds no register, so the first instruction never stalls.
- R2: A load marks its destination register. In the next accepted instruction, each checked, present source equal to that register adds exactly one cycle and adds one to the load-stall counter, so two matching sources add two. A load two instructions back never charges.
- R3: Class codes are exec 0, branch 1, load 2, store 3, load-multiple 4 and store-multiple 5. Exec and store check both sources. Branch and load check only the first source, so a match on the second source of a branch or load adds nothing.
- R4: A source whose presence flag is low is never checked and adds no cycle, whatever its register index.
- R5: A taken branch with its delay-slot flag low adds one cycle and increments the branch-stall counter. A taken branch with a delay slot adds nothing. An untaken branch adds nothing.
- R6: Every branch increments the taken counter when its taken flag is high and the untaken counter otherwise. Non-branch classes touch neither counter.
- R7: Load-multiple, store-multiple and the unused codes 6 and 7 report exactly their base count, perform no stall check, and clear the scoreboard.
- R8: The effective count appears on the last-instruction output on the clock edge that accepts the strobe, so it is readable one cycle after the strobe. It holds while no strobe arrives. Idle cycles leave the scoreboard unchanged.
- R9: Each effective count is added to the total-cycle counter. The load-stall counter grows by the number of stalls charged.
- R10: Every counter saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | One-cycle strobe for a retiring instruction |
| instr_class | input | 3 | Class code (see R3) |
| base_cycles | input | BASE_W | Nominal cycle count of the instruction |
| src0_reg | input | $clog2(NREG) | First source register index |
| src0_vld | input | 1 | First source is present |
| src1_reg | input | $clog2(NREG) | Second source register index |
| src1_vld | input | 1 | Second source is present |
| load_dst | input | $clog2(NREG) | Destination register of a load |
| br_taken | input | 1 | Branch was taken |
| br_has_slot | input | 1 | Branch has a delay slot |
| last_cycles | output | BASE_W+2 | Effective cost of the last accepted instruction |
| total_cycles | output | CNT_W | Saturating sum of effective costs |
| load_stall_cnt | output | CNT_W | Saturating count of load-use stall cycles |
| branch_stall_cnt | output | CNT_W | Saturating count of branch stall cycles |
| taken_cnt | output | CNT_W | Saturating count of taken branches |
| untaken_cnt | output | CNT_W | Saturating count of untaken branches |

## Verification
A branch can draw a load-use stall and a branch stall in the same cycle. This happens when its first source reads the register loaded by the instruction just before it, and it is taken with no delay slot. The instruction must then cost its base count plus two, and the load-stall counter and the branch-stall counter must each advance by one in the same edge. A directed sequence of a load followed by such a branch provokes this case, and the random stream hits it again. The stream uses only four register indices so that scoreboard hits are frequent. Each result is judged against a bench model that charges the two penalties independently and sums them.

// File: rtl/acct_pkg.sv
package acct_pkg;

    typedef enum logic [2:0] {
        CLS_EXEC   = 3'd0,
        CLS_BRANCH = 3'd1,
        CLS_LOAD   = 3'd2,
        CLS_STORE  = 3'd3,
        CLS_LDM    = 3'd4,
        CLS_STM    = 3'd5
    } instr_class_e;

    localparam int unsigned NUM_COUNTERS = 5;
    localparam int unsigned CNT_TOTAL    = 0;
    localparam int unsigned CNT_LSTALL   = 1;
    localparam int unsigned CNT_BSTALL   = 2;
    localparam int unsigned CNT_TAKEN    = 3;
    localparam int unsigned CNT_UNTAKEN  = 4;

endpackage

// File: rtl/acct_hazard.sv
// Scoreboard lookup: counts the sources of this instruction that read a
// register loaded by the previous one. Which sources count depends on class.
module acct_hazard
    import acct_pkg::*;
#(
    parameter int unsigned NREG  = 16,
    localparam int unsigned IDX_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]  active_mask,
    input  logic [2:0]       cls,
    input  logic [IDX_W-1:0] src0_reg,
    input  logic             src0_vld,
    input  logic [IDX_W-1:0] src1_reg,
    input  logic             src1_vld,
    output logic [1:0]       n_stall
);

    logic chk0;
    logic chk1;
    logic hit0;
    logic hit1;

    always_comb begin
        chk0 = 1'b0;
        chk1 = 1'b0;
        case (cls)
            CLS_EXEC, CLS_STORE: begin
                chk0 = 1'b1;
                chk1 = 1'b1;
            end
            CLS_BRANCH, CLS_LOAD: begin
                chk0 = 1'b1;
            end
            default: begin
                chk0 = 1'b0;
                chk1 = 1'b0;
            end
        endcase
        hit0    = chk0 && src0_vld && active_mask[src0_reg];
        hit1    = chk1 && src1_vld && active_mask[src1_reg];
        n_stall = {1'b0, hit0} + {1'b0, hit1};
    end

endmodule

// File: rtl/acct_branch.sv
// Branch outcome decode: stall penalty and taken/untaken events.
module acct_branch
    import acct_pkg::*;
(
    input  logic [2:0] cls,
    input  logic       taken,
    input  logic       has_slot,
    output logic       stall,
    output logic       taken_ev,
    output logic       untaken_ev
);

    logic is_br;

    always_comb begin
        is_br      = (cls == CLS_BRANCH);
        taken_ev   = is_br && taken;
        untaken_ev = is_br && !taken;
        stall      = taken_ev && !has_slot;
    end

endmodule

// File: rtl/acct_sat_add.sv
// Saturating accumulator step: y = min(a + inc, all-ones).
module acct_sat_add #(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = 10
) (
    input  logic [W-1:0]  a,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  y
);

    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, a} + {{(W + 1 - IW){1'b0}}, inc};
        y   = sum[W] ? {W{1'b1}} : sum[W-1:0];
    end

endmodule

// File: rtl/cycle_accounter.sv
module cycle_accounter
    import acct_pkg::*;
#(
    parameter int unsigned NREG   = 16,
    parameter int unsigned BASE_W = 8,
    parameter int unsigned CNT_W  = 32,
    localparam int unsigned IDX_W  = $clog2(NREG),
    localparam int unsigned LAST_W = BASE_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [2:0]        instr_class,
    input  logic [BASE_W-1:0] base_cycles,
    input  logic [IDX_W-1:0]  src0_reg,
    input  logic              src0_vld,
    input  logic [IDX_W-1:0]  src1_reg,
    input  logic              src1_vld,
    input  logic [IDX_W-1:0]  load_dst,
    input  logic              br_taken,
    input  logic              br_has_slot,
    output logic [LAST_W-1:0] last_cycles,
    output logic [CNT_W-1:0]  total_cycles,
    output logic [CNT_W-1:0]  load_stall_cnt,
    output logic [CNT_W-1:0]  branch_stall_cnt,
    output logic [CNT_W-1:0]  taken_cnt,
    output logic [CNT_W-1:0]  untaken_cnt
);

    typedef struct packed {
        logic [NREG-1:0]                      active;
        logic [LAST_W-1:0]                    last;
        logic [NUM_COUNTERS-1:0][CNT_W-1:0]   cnt;
    } acct_state_t;

    acct_state_t state_d;
    acct_state_t state_q;

    logic [1:0]  n_stall;
    logic        br_stall;
    logic        taken_ev;
    logic        untaken_ev;
    logic [LAST_W-1:0] eff_cycles;
    logic [NUM_COUNTERS-1:0][LAST_W-1:0] cnt_inc;
    logic [NUM_COUNTERS-1:0][CNT_W-1:0]  cnt_next;

    acct_hazard #(.NREG(NREG)) u_hazard (
        .active_mask (state_q.active),
        .cls         (instr_class),
        .src0_reg    (src0_reg),
        .src0_vld    (src0_vld),
        .src1_reg    (src1_reg),
        .src1_vld    (src1_vld),
        .n_stall     (n_stall)
    );

    acct_branch u_branch (
        .cls        (instr_class),
        .taken      (br_taken),
        .has_slot   (br_has_slot),
        .stall      (br_stall),
        .taken_ev   (taken_ev),
        .untaken_ev (untaken_ev)
    );

    // Per-counter increments; zero on cycles without a strobe.
    always_comb begin
        eff_cycles = {2'b00, base_cycles}
                   + {{(LAST_W-2){1'b0}}, n_stall}
                   + {{(LAST_W-1){1'b0}}, br_stall};
        cnt_inc = '0;
        if (instr_valid) begin
            cnt_inc[CNT_TOTAL]   = eff_cycles;
            cnt_inc[CNT_LSTALL]  = {{(LAST_W-2){1'b0}}, n_stall};
            cnt_inc[CNT_BSTALL]  = {{(LAST_W-1){1'b0}}, br_stall};
            cnt_inc[CNT_TAKEN]   = {{(LAST_W-1){1'b0}}, taken_ev};
            cnt_inc[CNT_UNTAKEN] = {{(LAST_W-1){1'b0}}, untaken_ev};
        end
    end

    for (genvar g = 0; g < NUM_COUNTERS; g++) begin : g_cnt
        acct_sat_add #(.W(CNT_W), .IW(LAST_W)) u_sat (
            .a   (state_q.cnt[g]),
            .inc (cnt_inc[g]),
            .y   (cnt_next[g])
        );
    end

    always_comb begin
        state_d = state_q;
        if (instr_valid) begin
            // Pending mask of this instruction becomes the active mask.
            if (instr_class == CLS_LOAD) begin
                state_d.active = NREG'(1) << load_dst;
            end else begin
                state_d.active = '0;
            end
            state_d.last = eff_cycles;
            state_d.cnt  = cnt_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign last_cycles      = state_q.last;
    assign total_cycles     = state_q.cnt[CNT_TOTAL];
    assign load_stall_cnt   = state_q.cnt[CNT_LSTALL];
    assign branch_stall_cnt = state_q.cnt[CNT_BSTALL];
    assign taken_cnt        = state_q.cnt[CNT_TAKEN];
    assign untaken_cnt      = state_q.cnt[CNT_UNTAKEN];

endmodule

// File: rtl/acct_checker.sv
module acct_checker
    import acct_pkg::*;
#(
    parameter int unsigned NREG   = 16,
    parameter int unsigned BASE_W = 8,
    parameter int unsigned CNT_W  = 32,
    localparam int unsigned IDX_W  = $clog2(NREG),
    localparam int unsigned LAST_W = BASE_W + 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              instr_valid,
    input logic [2:0]        instr_class,
    input logic [BASE_W-1:0] base_cycles,
    input logic              src0_vld,
    input logic              src1_vld,
    input logic              br_taken,
    input logic [LAST_W-1:0] last_cycles,
    input logic [CNT_W-1:0]  total_cycles,
    input logic [CNT_W-1:0]  untaken_cnt
);

    AST_COST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> (last_cycles >= {2'b00, $past(base_cycles)})
                     && (last_cycles <= {2'b00, $past(base_cycles)} + LAST_W'(2))); // R2

    AST_ABSENT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && !src0_vld && !src1_vld && instr_class != CLS_BRANCH
        |=> last_cycles == {2'b00, $past(base_cycles)}); // R4

    AST_UNTAKEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && instr_class == CLS_BRANCH && br_taken
        |=> $stable(untaken_cnt)); // R6

    AST_MULTI_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && (instr_class == CLS_LDM || instr_class == CLS_STM)
        |=> last_cycles == {2'b00, $past(base_cycles)}); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> $stable(last_cycles) && $stable(total_cycles)); // R8

    AST_TOTAL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid |=> total_cycles >= $past(total_cycles)); // R9

    AST_SAT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        total_cycles == {CNT_W{1'b1}} |=> total_cycles == {CNT_W{1'b1}}); // R10

endmodule

bind cycle_accounter acct_checker #(
    .NREG(NREG), .BASE_W(BASE_W), .CNT_W(CNT_W)
) u_acct_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_valid  (instr_valid),
    .instr_class  (instr_class),
    .base_cycles  (base_cycles),
    .src0_vld     (src0_vld),
    .src1_vld     (src1_vld),
    .br_taken     (br_taken),
    .last_cycles  (last_cycles),
    .total_cycles (total_cycles),
    .untaken_cnt  (untaken_cnt)
);

// File: tb/test_cycle_accounter.sv
`timescale 1ns/1ps
module test_cycle_accounter;

    localparam int unsigned NREG   = 16;
    localparam int unsigned BASE_W = 8;
    localparam int unsigned CNT_W  = 16;   // narrow so saturation is reachable
    localparam int unsigned IDX_W  = $clog2(NREG);
    localparam int unsigned LAST_W = BASE_W + 2;
    localparam longint      CMAX   = (64'd1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              instr_valid = 1'b0;
    logic [2:0]        instr_class = '0;
    logic [BASE_W-1:0] base_cycles = '0;
    logic [IDX_W-1:0]  src0_reg = '0;
    logic              src0_vld = 1'b0;
    logic [IDX_W-1:0]  src1_reg = '0;
    logic              src1_vld = 1'b0;
    logic [IDX_W-1:0]  load_dst = '0;
    logic              br_taken = 1'b0;
    logic              br_has_slot = 1'b0;
    logic [LAST_W-1:0] last_cycles;
    logic [CNT_W-1:0]  total_cycles;
    logic [CNT_W-1:0]  load_stall_cnt;
    logic [CNT_W-1:0]  branch_stall_cnt;
    logic [CNT_W-1:0]  taken_cnt;
    logic [CNT_W-1:0]  untaken_cnt;

    always #10 clk = ~clk;   // 50 MHz

    cycle_accounter #(.NREG(NREG), .BASE_W(BASE_W), .CNT_W(CNT_W)) i_cycle_accounter (
        .clk, .rst_n, .instr_valid, .instr_class, .base_cycles,
        .src0_reg, .src0_vld, .src1_reg, .src1_vld, .load_dst,
        .br_taken, .br_has_slot, .last_cycles, .total_cycles,
        .load_stall_cnt, .branch_stall_cnt, .taken_cnt, .untaken_cnt
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench model state
    logic [NREG-1:0] m_active = '0;
    longint m_last = 0, m_total = 0, m_ls = 0, m_bs = 0, m_tk = 0, m_ut = 0;

    function automatic longint sat(longint a, longint b);
        return (a + b > CMAX) ? CMAX : a + b;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all();
        check("R2 R8 last_cycles", longint'(last_cycles), m_last);
        check("R9 R10 total", longint'(total_cycles), m_total);
        check("R2 load-stall", longint'(load_stall_cnt), m_ls);
        check("R5 branch-stall", longint'(branch_stall_cnt), m_bs);
        check("R6 taken", longint'(taken_cnt), m_tk);
        check("R6 untaken", longint'(untaken_cnt), m_ut);
    endtask

    // Drive one instruction at a falling edge, update the model, check after.
    task automatic instr(int cls, int base, int s0, bit v0, int s1, bit v1,
                         int dst, bit tk, bit ds);
        int  st;
        bit  c0, c1, bst;
        instr_valid = 1'b1;
        instr_class = 3'(cls);
        base_cycles = BASE_W'(base);
        src0_reg = IDX_W'(s0); src0_vld = v0;
        src1_reg = IDX_W'(s1); src1_vld = v1;
        load_dst = IDX_W'(dst);
        br_taken = tk; br_has_slot = ds;
        c0 = (cls <= 3);                  // exec, branch, load, store
        c1 = (cls == 0 || cls == 3);      // exec, store
        st = 0;
        if (c0 && v0 && m_active[s0]) st++;
        if (c1 && v1 && m_active[s1]) st++;
        bst = (cls == 1) && tk && !ds;
        m_last  = base + st + int'(bst);
        m_total = sat(m_total, m_last);
        m_ls    = sat(m_ls, st);
        m_bs    = sat(m_bs, bst);
        if (cls == 1) begin
            if (tk) m_tk = sat(m_tk, 1);
            else    m_ut = sat(m_ut, 1);
        end
        m_active = (cls == 2) ? (NREG'(1) << dst) : '0;
        @(negedge clk);
        instr_valid = 1'b0;
        check_all();
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();                               // R1 reset values
        instr(0, 5, 3, 1, 3, 1, 0, 0, 0);          // R1 first instr no stall
        // R2: load r3, exec reads r3 twice -> +2
        instr(2, 4, 0, 0, 0, 0, 3, 0, 0);
        instr(0, 6, 3, 1, 3, 1, 0, 0, 0);
        // R8: idle gaps keep the scoreboard
        instr(2, 2, 0, 0, 0, 0, 7, 0, 0);
        idle(3);
        instr(3, 3, 1, 1, 7, 1, 0, 0, 0);
        // R2: load two back does not stall
        instr(2, 2, 0, 0, 0, 0, 5, 0, 0);
        instr(2, 2, 0, 0, 0, 0, 6, 0, 0);
        instr(0, 1, 5, 1, 2, 1, 0, 0, 0);
        // R3: branch second source ignored; load second source ignored
        instr(2, 2, 0, 0, 0, 0, 9, 0, 0);
        instr(1, 2, 1, 1, 9, 1, 0, 0, 1);
        instr(2, 2, 0, 0, 0, 0, 9, 0, 0);
        instr(2, 2, 4, 1, 9, 1, 1, 0, 0);
        // R4: absent sources never charged
        instr(2, 2, 0, 0, 0, 0, 8, 0, 0);
        instr(0, 7, 8, 0, 8, 0, 0, 0, 0);
        // R7: multiples and codes 6/7 report base only
        instr(2, 2, 0, 0, 0, 0, 2, 0, 0);
        instr(4, 9, 2, 1, 2, 1, 0, 0, 0);
        instr(2, 2, 0, 0, 0, 0, 2, 0, 0);
        instr(7, 9, 2, 1, 2, 1, 0, 0, 0);
        // R5 R6: branch variants; load stall and branch stall together
        instr(1, 3, 0, 0, 0, 0, 0, 1, 0);
        instr(1, 3, 0, 0, 0, 0, 0, 1, 1);
        instr(1, 3, 0, 0, 0, 0, 0, 0, 0);
        instr(2, 2, 0, 0, 0, 0, 4, 0, 0);
        instr(1, 3, 4, 1, 0, 0, 0, 1, 0);
        // Random stream, until total saturates and beyond (R10)
        for (int i = 0; i < 1500; i++) begin
            instr(int'($urandom % 8), int'($urandom % 256),
                  int'($urandom % 4), bit'($urandom % 2),
                  int'($urandom % 4), bit'($urandom % 2),
                  int'($urandom % 4), bit'($urandom % 2), bit'($urandom % 2));
            if ($urandom % 8 == 0) idle(1);
        end
        check("R10 total saturated", longint'(total_cycles), CMAX);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule